// File: doc/BRIEF.md
# Parallel Port FIFO Forward Engine

This block takes bytes that the host loads through I/O writes or DMA writes into a small on-chip FIFO. It sends them out, one at a time, on an 8-bit parallel data bus. Each byte is paced by a strobe/busy handshake against the attached peripheral. The direction output is held low, because only forward (host-to-peripheral) transfers are carried out.

A 3-bit mode field selects the behaviour. Value 010 is a plain FIFO printer mode. In it, only the upper FIFO port and DMA load bytes. Value 011 is an extended-capability forward mode. In it, every FIFO entry also carries a ninth tag bit. The path that wrote the entry decides the tag, and the tag is driven on the auto-feed line together with its byte. Any other mode value stops the engine. A handshake in progress is aborted, and host writes are not accepted.

The setup time between presenting a byte and pulling the strobe low is a parameter counted in clock cycles.

Top module: `ppf_fwd_engine`

## Requirements
- R1: After synchronous reset, `strobe_n_o` and `autofd_n_o` are 1, `pd_o` is 0, `fifo_empty_o` is 1, and both `fifo_full_o` and `overflow_o` are 0.
- R2: `pdir_o` is 0 at all times.
- R3: In mode 010, a host write with `io_hi_i`=1 (upper port) and a DMA write each load one byte. A host write with `io_hi_i`=0 (lower port) is ignored.
- R4: In mode 011, a host write to the lower port stores tag 0, and a host write to the upper port or a DMA write stores tag 1. While the byte is presented, `autofd_n_o` carries its tag level. In mode 010, `autofd_n_o` stays 1.
- R5: With any mode other than 010 or 011, writes are ignored and no strobe is produced.
- R6: Bytes leave in the order in which they were accepted.
- R7: A byte is taken from the FIFO only while `busy_i` is 0. `pd_o` changes exactly SETUP_CLKS+1 clock edges before `strobe_n_o` falls, counted from the edge that accepts a write into an idle, empty engine. `pd_o` stays stable while `strobe_n_o` is 0.
- R8: `strobe_n_o` stays 0 until `busy_i` is seen at 1, and then returns to 1. The next byte is not started until `busy_i` is back at 0.
- R9: The FIFO holds 16 entries, and `fifo_full_o` reports 16. A write that is accepted by the mode but arrives while the FIFO is full is dropped, and it sets `overflow_o`. `overflow_o` stays 1 until reset.
- R10: When the mode leaves 010/011, `strobe_n_o` is 1 after the next clock edge, and it stays 1.
- R11: When an accepted host write and a DMA write arrive in the same cycle, the host byte is stored and the DMA byte is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 3 | Mode field: 010 FIFO printer, 011 extended forward, others stopped |
| io_wr_i | input | 1 | Host I/O write strobe, one cycle per byte |
| io_hi_i | input | 1 | Host port select: 1 upper FIFO port, 0 lower FIFO port |
| io_data_i | input | 8 | Host write byte |
| dma_wr_i | input | 1 | DMA write strobe, one cycle per byte |
| dma_data_i | input | 8 | DMA write byte |
| busy_i | input | 1 | Peripheral busy line |
| pd_o | output | 8 | Parallel data bus |
| strobe_n_o | output | 1 | Active-low data strobe |
| autofd_n_o | output | 1 | Tag line (extended mode), high otherwise |
| pdir_o | output | 1 | Bus direction, 0 = forward |
| fifo_empty_o | output | 1 | FIFO holds no entry |
| fifo_full_o | output | 1 | FIFO holds 16 entries |
| overflow_o | output | 1 | Sticky: an accepted write was dropped on a full FIFO |

## Verification
Directed sequences try each write path on its own in both modes, and also the host and DMA paths in the same cycle. Together they show which path is accepted and which tag each path stores. A bench-side peripheral model answers every strobe after a random delay, so strobe holding and busy pacing are tried over many timings, not one fixed latency. Filling the FIFO with busy held high separates the pop-gating from the full and overflow logic. Switching the mode in the middle of a handshake shows the abort apart from a normal release. Random mixed write streams in both modes then confirm order and tags under back-pressure.

// File: rtl/ppf_pkg.sv
// Package: shared codes and types for the parallel port forward engine.
// Assumes: mode encodings are fixed by the surrounding register block.
package ppf_pkg;
    localparam logic [2:0] MODE_PRN = 3'b010;   // FIFO printer mode
    localparam logic [2:0] MODE_EXT = 3'b011;   // extended forward mode

    typedef struct packed {
        logic       tag;
        logic [7:0] data;
    } ppf_entry_t;

    typedef enum logic [1:0] {
        HS_IDLE    = 2'd0,
        HS_SETUP   = 2'd1,
        HS_STROBE  = 2'd2,
        HS_RELEASE = 2'd3
    } hs_state_t;
endpackage

// File: rtl/ppf_wr_decode.sv
// Module: write-path decoder. Picks which host/DMA write enters the FIFO
// and which tag it carries. Pure combinational; at most one push per cycle,
// the host write having priority over DMA.
module ppf_wr_decode
    import ppf_pkg::*;
(
    input  logic [2:0] mode_i,
    input  logic       io_wr_i,
    input  logic       io_hi_i,
    input  logic [7:0] io_data_i,
    input  logic       dma_wr_i,
    input  logic [7:0] dma_data_i,
    output logic       push_o,
    output ppf_entry_t entry_o
);
    logic io_take;
    logic dma_take;

    // Accept rules per mode and host-over-DMA priority.
    always_comb begin
        io_take  = 1'b0;
        dma_take = 1'b0;
        if (mode_i == MODE_PRN) begin
            io_take  = io_wr_i && io_hi_i;
            dma_take = dma_wr_i && !io_take;
        end else if (mode_i == MODE_EXT) begin
            io_take  = io_wr_i;
            dma_take = dma_wr_i && !io_take;
        end
        push_o = io_take || dma_take;
        if (io_take) begin
            entry_o.data = io_data_i;
            entry_o.tag  = io_hi_i;
        end else begin
            entry_o.data = dma_data_i;
            entry_o.tag  = 1'b1;
        end
    end
endmodule

// File: rtl/ppf_fifo.sv
// Module: synchronous FIFO of tagged bytes with a sticky overflow flag.
// Assumes DEPTH is a power of two. A push while full is dropped even if a
// pop happens in the same cycle.
module ppf_fifo
    import ppf_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       push_i,
    input  ppf_entry_t entry_i,
    input  logic       pop_i,
    output ppf_entry_t head_o,
    output logic       empty_o,
    output logic       full_o,
    output logic       overflow_o
);
    localparam int AW = $clog2(DEPTH);

    ppf_entry_t     mem [DEPTH];
    logic [AW-1:0]  wr_ptr;
    logic [AW-1:0]  rd_ptr;
    logic [AW:0]    count;
    logic           do_push;
    logic           do_pop;

    assign empty_o = (count == '0);
    assign full_o  = (count == (AW+1)'(DEPTH));
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign head_o  = mem[rd_ptr];

    // Storage write; entries need no reset.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= entry_i;
    end

    // Pointer, occupancy and sticky overflow bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr     <= '0;
            rd_ptr     <= '0;
            count      <= '0;
            overflow_o <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
            if (push_i && full_o) overflow_o <= 1'b1;
        end
    end
endmodule

// File: rtl/ppf_handshake.sv
// Module: per-byte strobe/busy sequencer. Pops one entry when busy is low,
// holds it for SETUP_CLKS cycles, drops the strobe, waits for busy high,
// releases, then waits for busy low. Leaving the enabled modes aborts.
// Assumes SETUP_CLKS >= 1.
module ppf_handshake
    import ppf_pkg::*;
#(
    parameter int SETUP_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run_i,
    input  logic       ext_mode_i,
    input  logic       busy_i,
    input  logic       empty_i,
    input  ppf_entry_t head_i,
    output logic       pop_o,
    output logic [7:0] pd_o,
    output logic       autofd_n_o,
    output logic       strobe_n_o
);
    localparam int CW = (SETUP_CLKS > 1) ? $clog2(SETUP_CLKS) : 1;

    hs_state_t     state;
    logic [CW-1:0] setup_cnt;
    logic          tag_q;

    assign pop_o      = run_i && (state == HS_IDLE) && !empty_i && !busy_i;
    assign strobe_n_o = (state != HS_STROBE);
    assign autofd_n_o = ext_mode_i ? tag_q : 1'b1;

    // Handshake state machine and output data register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= HS_IDLE;
            setup_cnt <= '0;
            pd_o      <= '0;
            tag_q     <= 1'b1;
        end else if (!run_i) begin
            state     <= HS_IDLE;
            setup_cnt <= '0;
        end else begin
            case (state)
                HS_IDLE: if (pop_o) begin
                    pd_o      <= head_i.data;
                    tag_q     <= head_i.tag;
                    setup_cnt <= CW'(SETUP_CLKS - 1);
                    state     <= HS_SETUP;
                end
                HS_SETUP: begin
                    if (setup_cnt == '0) state <= HS_STROBE;
                    else                 setup_cnt <= setup_cnt - 1'b1;
                end
                HS_STROBE:  if (busy_i)  state <= HS_RELEASE;
                HS_RELEASE: if (!busy_i) state <= HS_IDLE;
                default:    state <= HS_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ppf_fwd_engine.sv
// Module: top of the parallel port forward engine. Decodes host/DMA writes
// into a tagged FIFO and drains it through the strobe/busy sequencer.
// Assumes one write per cycle per path and a synchronous busy input.
module ppf_fwd_engine
    import ppf_pkg::*;
#(
    parameter int DEPTH      = 16,
    parameter int SETUP_CLKS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_i,
    input  logic       io_wr_i,
    input  logic       io_hi_i,
    input  logic [7:0] io_data_i,
    input  logic       dma_wr_i,
    input  logic [7:0] dma_data_i,
    input  logic       busy_i,
    output logic [7:0] pd_o,
    output logic       strobe_n_o,
    output logic       autofd_n_o,
    output logic       pdir_o,
    output logic       fifo_empty_o,
    output logic       fifo_full_o,
    output logic       overflow_o
);
    logic       push;
    logic       pop;
    ppf_entry_t wr_entry;
    ppf_entry_t head;
    logic       run;
    logic       ext_mode;

    assign ext_mode = (mode_i == MODE_EXT);
    assign run      = (mode_i == MODE_PRN) || ext_mode;
    assign pdir_o   = 1'b0;

    ppf_wr_decode u_dec (
        .mode_i     (mode_i),
        .io_wr_i    (io_wr_i),
        .io_hi_i    (io_hi_i),
        .io_data_i  (io_data_i),
        .dma_wr_i   (dma_wr_i),
        .dma_data_i (dma_data_i),
        .push_o     (push),
        .entry_o    (wr_entry)
    );

    ppf_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push),
        .entry_i    (wr_entry),
        .pop_i      (pop),
        .head_o     (head),
        .empty_o    (fifo_empty_o),
        .full_o     (fifo_full_o),
        .overflow_o (overflow_o)
    );

    ppf_handshake #(.SETUP_CLKS(SETUP_CLKS)) u_hs (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (run),
        .ext_mode_i (ext_mode),
        .busy_i     (busy_i),
        .empty_i    (fifo_empty_o),
        .head_i     (head),
        .pop_o      (pop),
        .pd_o       (pd_o),
        .autofd_n_o (autofd_n_o),
        .strobe_n_o (strobe_n_o)
    );
endmodule

// File: rtl/ppf_fwd_checker.sv
// Module: port-level property checker for the forward engine, bound to top.
module ppf_fwd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] mode_i,
    input logic       io_wr_i,
    input logic       busy_i,
    input logic [7:0] pd_o,
    input logic       strobe_n_o,
    input logic       fifo_empty_o,
    input logic       fifo_full_o,
    input logic       overflow_o
);
    logic mode_on;
    assign mode_on = (mode_i == 3'b010) || (mode_i == 3'b011);

    p_strobe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n_o && !busy_i && mode_on) |=> !strobe_n_o);

    p_pd_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe_n_o |=> $stable(pd_o));

    p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_on |=> strobe_n_o);

    p_full_not_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full_o |-> !fifo_empty_o);

    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_o |=> overflow_o);

    p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_full_o && mode_i == 3'b011 && io_wr_i) |=> overflow_o);
endmodule

bind ppf_fwd_engine ppf_fwd_checker u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_i       (mode_i),
    .io_wr_i      (io_wr_i),
    .busy_i       (busy_i),
    .pd_o         (pd_o),
    .strobe_n_o   (strobe_n_o),
    .fifo_empty_o (fifo_empty_o),
    .fifo_full_o  (fifo_full_o),
    .overflow_o   (overflow_o)
);

// File: tb/ppf_fwd_engine_tb.sv
module ppf_fwd_engine_tb;
    localparam int SETUP = 2;
    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode = 3'b000;
    logic       io_wr = 1'b0, io_hi = 1'b0, dma_wr = 1'b0;
    logic [7:0] io_data = '0, dma_data = '0;
    logic       busy = 1'b0;
    logic [7:0] pd;
    logic       strobe_n, autofd_n, pdir, empty, full, ovf;

    int checks = 0;
    int fails  = 0;
    bit resp_en = 1'b0;
    logic [8:0] exp_q[$];

    always #5 clk = ~clk;

    ppf_fwd_engine #(.DEPTH(DEPTH), .SETUP_CLKS(SETUP)) u_dut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode),
        .io_wr_i(io_wr), .io_hi_i(io_hi), .io_data_i(io_data),
        .dma_wr_i(dma_wr), .dma_data_i(dma_data), .busy_i(busy),
        .pd_o(pd), .strobe_n_o(strobe_n), .autofd_n_o(autofd_n),
        .pdir_o(pdir), .fifo_empty_o(empty), .fifo_full_o(full),
        .overflow_o(ovf)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected acceptance per requirement R3, R4, R5, R11.
    function automatic bit exp_accept(input logic [2:0] m, input bit io, input bit hi, input bit dma);
        if (m == 3'b010) return (io && hi) || dma;
        if (m == 3'b011) return io || dma;
        return 1'b0;
    endfunction

    // Expected {autofd level, byte} seen at the strobe (R4, R11).
    function automatic logic [8:0] exp_word(input logic [2:0] m, input bit io, input bit hi,
                                            input logic [7:0] iod, input logic [7:0] dmad);
        bit host;
        bit tag;
        logic [7:0] d;
        host = (m == 3'b011) ? io : (io && hi);
        tag  = host ? hi : 1'b1;
        d    = host ? iod : dmad;
        return {(m == 3'b011) ? tag : 1'b1, d};
    endfunction

    task automatic do_wr(input bit io, input bit hi, input logic [7:0] iod,
                         input bit dma, input logic [7:0] dmad);
        @(negedge clk);
        if (exp_accept(mode, io, hi, dma) && !full)
            exp_q.push_back(exp_word(mode, io, hi, iod, dmad));
        io_wr = io; io_hi = hi; io_data = iod; dma_wr = dma; dma_data = dmad;
        @(posedge clk); #1;
        io_wr = 1'b0; dma_wr = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 4000; i++) begin
            @(posedge clk); #1;
            if (exp_q.size() == 0 && empty && strobe_n && !busy) break;
        end
        chk(exp_q.size() == 0, "R6 drain", exp_q.size(), 0);
    endtask

    // Peripheral model: captures each byte at the strobe fall, answers busy.
    initial begin
        forever begin
            @(negedge strobe_n);
            #1;
            if (resp_en) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected strobe", {autofd_n, pd}, 0);
                end else begin
                    logic [8:0] e;
                    e = exp_q.pop_front();
                    chk({autofd_n, pd} == e, "R4/R6 byte+tag", {autofd_n, pd}, e);
                end
                repeat ($urandom_range(1, 4)) @(posedge clk);
                #1;
                chk(strobe_n == 1'b0, "R8 strobe held", strobe_n, 0);
                busy = 1'b1;
                while (strobe_n == 1'b0) begin @(posedge clk); #1; end
                repeat ($urandom_range(0, 3)) @(posedge clk);
                #1;
                chk(strobe_n == 1'b1, "R8 no restart while busy", strobe_n, 1);
                busy = 1'b0;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        chk(strobe_n && autofd_n && pd == 8'h00, "R1 outputs", {strobe_n, autofd_n, pd}, 10'h300);
        chk(empty && !full && !ovf, "R1 flags", {empty, full, ovf}, 3'b100);
        chk(pdir == 1'b0, "R2 pdir", pdir, 0);

        // R5: stopped mode ignores both paths.
        resp_en = 1'b1;
        do_wr(1, 1, 8'h11, 0, 8'h00);
        chk(empty, "R5 host write ignored", empty, 1);
        do_wr(0, 0, 8'h00, 1, 8'h22);
        chk(empty, "R5 dma write ignored", empty, 1);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #1;
            chk(strobe_n, "R5 no strobe", strobe_n, 1);
        end

        // R3: printer mode paths.
        mode = 3'b010;
        do_wr(1, 0, 8'h33, 0, 8'h00);
        chk(empty, "R3 lower port ignored", empty, 1);
        do_wr(1, 1, 8'hA5, 0, 8'h00);
        do_wr(0, 0, 8'h00, 1, 8'h5A);
        drain();

        // R7: setup timing from a write into an idle engine.
        do_wr(1, 1, 8'hC3, 0, 8'h00);
        repeat (SETUP) @(posedge clk);
        #1;
        chk(strobe_n == 1'b1 && pd == 8'hC3, "R7 setup before strobe", {strobe_n, pd}, 9'h1C3);
        @(posedge clk); #1;
        chk(strobe_n == 1'b0, "R7 strobe after setup", strobe_n, 0);
        drain();

        // R4, R11: tags in extended mode.
        mode = 3'b011;
        do_wr(1, 0, 8'h01, 0, 8'h00);
        do_wr(1, 1, 8'h02, 0, 8'h00);
        do_wr(0, 0, 8'h00, 1, 8'h03);
        do_wr(1, 0, 8'h04, 1, 8'h99);
        drain();

        // R9: fill with busy high, no pop may happen (R7), then overflow.
        resp_en = 1'b0;
        busy = 1'b1;
        for (int i = 0; i < DEPTH; i++) do_wr(1, 1, 8'(8'h40 + i), 0, 8'h00);
        chk(full && !ovf, "R9 full at 16", {full, ovf}, 2'b10);
        do_wr(1, 0, 8'hEE, 0, 8'h00);
        chk(ovf && full, "R9 overflow set", {ovf, full}, 2'b11);
        @(negedge clk);
        resp_en = 1'b1;
        busy = 1'b0;
        drain();
        chk(ovf, "R9 overflow sticky", ovf, 1);

        // R10: abort a held strobe.
        resp_en = 1'b0;
        do_wr(0, 0, 8'h00, 1, 8'h77);
        for (int i = 0; i < 20 && strobe_n; i++) begin @(posedge clk); #1; end
        chk(strobe_n == 1'b0, "R10 strobe reached", strobe_n, 0);
        @(negedge clk);
        mode = 3'b000;
        @(posedge clk); #1;
        chk(strobe_n == 1'b1, "R10 abort release", strobe_n, 1);
        exp_q.delete();
        repeat (4) @(posedge clk);
        #1;
        chk(strobe_n == 1'b1, "R10 stays released", strobe_n, 1);
        do_wr(1, 1, 8'h12, 1, 8'h34);
        chk(empty, "R5 write ignored after abort", empty, 1);

        // Random mixed streams in both modes.
        resp_en = 1'b1;
        for (int ph = 0; ph < 2; ph++) begin
            mode = (ph == 0) ? 3'b011 : 3'b010;
            for (int i = 0; i < 150; i++) begin
                do_wr(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 8'($urandom),
                      1'($urandom_range(0, 1)), 8'($urandom));
                repeat ($urandom_range(0, 3)) @(posedge clk);
            end
            drain();
        end
        chk(pdir == 1'b0, "R2 pdir end", pdir, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule